// File: doc/BRIEF.md
# Operand-Cache RAM-Mode Address Mapper

This block lets half of the operand-cache data array serve as directly addressed on-chip RAM. When the RAM-mode configuration bit is set and the index-mode option is clear, CPU accesses whose address falls in the top 64 MB window of the lower half of the address space are decoded onto two fixed ranges of cache entries. The block returns the entry index and the 64-bit word within the line, and it reads or writes the data array. The data array is modelled here as a simple 64-bit-wide memory that covers only the RAM entries.

Two areas of 4 KB each are carved out. The first is entries 128 to 255 and the second is entries 384 to 511. At the same time the block drives a per-entry allocation mask to the replacement logic, so the cache never fills those entries. Instruction fetches into the window are refused, and so are accesses that are not aligned to their own size. The block raises an error flag for them and makes no array access.

Top module: `ocram_mapper`

## Requirements
- R1: When the RAM-mode bit `ram_en` is 0, `ram_hit` and `err` stay 0, no array access takes place, and every bit of `alloc_mask` is 1.
- R2: With RAM mode on, an access hits the window only if address bits [31:26] equal 6'b011111, which is 0x7C00_0000 to 0x7FFF_FFFF. Any other address gives neither `ram_hit` nor `err`.
- R3: For a window hit, `entry_idx` is 128 plus address bits [11:5] when address bit 12 is 0, and 384 plus address bits [11:5] when address bit 12 is 1.
- R4: For a window hit, `word_sel` equals address bits [4:3], which selects one of the four 64-bit words in a 32-byte line.
- R5: While RAM mode is active, `alloc_mask[i]` is 0 for every entry i with index bit 7 set (128 to 255 and 384 to 511) and 1 for every other entry.
- R6: An access in the window with `acc_kind` equal to 2 (fetch) or 3 (reserved) sets `err`, clears `ram_hit`, and leaves the array unchanged.
- R7: A read or write in the window that is misaligned for its size sets `err` and suppresses any write. Sizes are coded in `acc_size` as 0 byte, 1 word, 2 longword and 3 quadword, and an access is misaligned when any of the low `acc_size` address bits is 1.
- R8: A legal write (`acc_kind` 1) updates only byte lanes addr[2:0] up to addr[2:0]+2^size-1 of the 64-bit word, taking lane b from `wr_data[8b+7:8b]`. A legal read (`acc_kind` 0) sets `rd_valid` and `rd_data` to the whole word on the cycle after the request.
- R9: Address bits [25:13] are ignored, so the 8 KB pattern repeats across the whole window.
- R10: While `idx_mode` is 1, RAM mode is inactive and the block behaves exactly as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ram_en | input | 1 | RAM-mode configuration bit |
| idx_mode | input | 1 | Index-mode configuration bit (blocks RAM mode) |
| acc_valid | input | 1 | Access request |
| acc_addr | input | 32 | CPU physical address |
| acc_size | input | 2 | 0 byte, 1 word, 2 longword, 3 quadword |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| wr_data | input | 64 | Write data, lane-aligned |
| ram_hit | output | 1 | Legal access served by the RAM |
| err | output | 1 | Illegal access in the window |
| entry_idx | output | 9 | Cache entry addressed |
| word_sel | output | 2 | 64-bit word within the line |
| alloc_mask | output | 512 | Per-entry allocation permission |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |

## Verification
Partial writes are the hardest to observe. A narrow write changes only some lanes, and the only way to see the result is a later full read through the mirrored window. The stimulus therefore first fills all 1024 words with quadword writes through one mirror, then overlays byte, word and longword writes through other mirrors, and reads back through yet another mirror. Each readback is compared with a lane-by-lane model kept in the bench. Rejected fetches and misaligned writes are each followed by a readback of the word they aimed at, which shows that the word did not change.

// File: rtl/ocram_mapper.sv
module ocram_mapper #(
  parameter int ENTRIES    = 512,
  parameter int LINE_BYTES = 32,
  parameter int DATA_BYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ram_en,
  input  logic                       idx_mode,
  input  logic                       acc_valid,
  input  logic [31:0]                acc_addr,
  input  logic [1:0]                 acc_size,
  input  logic [1:0]                 acc_kind,
  input  logic [8*DATA_BYTES-1:0]    wr_data,
  output logic                       ram_hit,
  output logic                       err,
  output logic [$clog2(ENTRIES)-1:0] entry_idx,
  output logic [$clog2(LINE_BYTES/DATA_BYTES)-1:0] word_sel,
  output logic [ENTRIES-1:0]         alloc_mask,
  output logic                       rd_valid,
  output logic [8*DATA_BYTES-1:0]    rd_data
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int OFS_W   = $clog2(LINE_BYTES);
  localparam int LANE_W  = $clog2(DATA_BYTES);
  localparam int WSEL_W  = OFS_W - LANE_W;
  localparam int AREA_L  = ENTRIES / 4;
  localparam int LINE_W  = $clog2(AREA_L);
  localparam int AREA_B  = OFS_W + LINE_W;
  localparam int MEM_AW  = 1 + LINE_W + WSEL_W;
  localparam int DEPTH   = 1 << MEM_AW;
  localparam int DW      = 8 * DATA_BYTES;

  logic              mode_on, in_win, is_fetch, misal, legal;
  logic [LANE_W-1:0] size_mask;
  logic [DATA_BYTES-1:0] be;
  logic [MEM_AW-1:0] mem_a;
  logic [DW-1:0]     mem [DEPTH];

  assign mode_on   = ram_en & ~idx_mode;
  assign in_win    = acc_valid & mode_on & (acc_addr[31:26] == 6'b011111);
  assign is_fetch  = acc_kind[1];
  assign size_mask = LANE_W'((32'd1 << acc_size) - 32'd1);
  assign misal     = |(acc_addr[LANE_W-1:0] & size_mask);
  assign legal     = ~is_fetch & ~misal;
  assign ram_hit   = in_win & legal;
  assign err       = in_win & ~legal;

  assign entry_idx = {acc_addr[AREA_B], 1'b1, acc_addr[AREA_B-1:OFS_W]};
  assign word_sel  = acc_addr[OFS_W-1:LANE_W];
  assign mem_a     = {acc_addr[AREA_B], acc_addr[AREA_B-1:OFS_W], acc_addr[OFS_W-1:LANE_W]};
  assign be        = DATA_BYTES'(((32'd1 << (32'd1 << acc_size)) - 32'd1) << acc_addr[LANE_W-1:0]);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_alloc
    localparam bit RAM_ENT = ((i / AREA_L) % 2) == 1;
    assign alloc_mask[i] = ~(mode_on & RAM_ENT);
  end

  always_ff @(posedge clk) begin
    if (ram_hit && acc_kind == 2'd1)
      for (int b = 0; b < DATA_BYTES; b++)
        if (be[b]) mem[mem_a][8*b +: 8] <= wr_data[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= ram_hit & (acc_kind == 2'd0);
      if (ram_hit && acc_kind == 2'd0) rd_data <= mem[mem_a];
    end
  end
  localparam int UNUSED_IDX = IDX_W;
endmodule

// File: rtl/ocram_mapper_chk.sv
module ocram_mapper_chk #(
  parameter int ENTRIES = 512
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ram_en,
  input logic               idx_mode,
  input logic               acc_valid,
  input logic [31:0]        acc_addr,
  input logic [1:0]         acc_kind,
  input logic               ram_hit,
  input logic               err,
  input logic [8:0]         entry_idx,
  input logic [ENTRIES-1:0] alloc_mask,
  input logic               rd_valid
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_en && !idx_mode) |-> (!ram_hit && !err && &alloc_mask)); // R1
  AST_WIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[31:26] != 6'b011111) |-> (!ram_hit && !err)); // R2
  AST_ENTRY_RAMSET: assert property (@(posedge clk) disable iff (!rst_n)
    ram_hit |-> entry_idx[7]); // R3
  AST_ALLOC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !idx_mode) |-> (!alloc_mask[128] && !alloc_mask[511] && alloc_mask[0] && alloc_mask[383])); // R5
  AST_FETCH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ram_en && !idx_mode && acc_addr[31:26] == 6'b011111 && acc_kind[1]) |-> (err && !ram_hit)); // R6
  AST_HIT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_hit && err)); // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit && acc_kind == 2'd0) |=> rd_valid); // R8
  AST_RD_NOSPUR: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_hit && acc_kind == 2'd0) |=> !rd_valid); // R8
endmodule

bind ocram_mapper ocram_mapper_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ram_en(ram_en), .idx_mode(idx_mode),
  .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
  .ram_hit(ram_hit), .err(err), .entry_idx(entry_idx),
  .alloc_mask(alloc_mask), .rd_valid(rd_valid)
);

// File: tb/ocram_mapper_bench.sv
module ocram_mapper_bench;
  logic clk = 0, rst_n = 0;
  logic ram_en = 0, idx_mode = 0, acc_valid = 0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0, acc_kind = '0;
  logic [63:0] wr_data = '0;
  logic ram_hit, err, rd_valid;
  logic [8:0] entry_idx;
  logic [1:0] word_sel;
  logic [511:0] alloc_mask;
  logic [63:0] rd_data;

  logic [63:0] model [1024];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ocram_mapper u_ocram_mapper (
    .clk(clk), .rst_n(rst_n), .ram_en(ram_en), .idx_mode(idx_mode),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_kind(acc_kind), .wr_data(wr_data), .ram_hit(ram_hit), .err(err),
    .entry_idx(entry_idx), .word_sel(word_sel), .alloc_mask(alloc_mask),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int widx(input logic [31:0] a);
    return int'(a[12]) * 512 + int'(a[11:5]) * 4 + int'(a[4:3]);
  endfunction

  // one access: drive at negedge, check decode, clock, return to idle
  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] k,
                     input logic [63:0] d, input bit exp_hit, input bit exp_err);
    int eent;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_size = sz; acc_kind = k; wr_data = d;
    #1;
    chk(ram_hit == exp_hit, "R2/R6/R7 ram_hit", 64'(ram_hit), 64'(exp_hit));
    chk(err == exp_err, "R6/R7 err", 64'(err), 64'(exp_err));
    if (exp_hit) begin
      eent = (a[12] ? 384 : 128) + int'((a >> 5) & 32'd127);
      chk(int'(entry_idx) == eent, "R3 entry_idx", 64'(entry_idx), 64'(eent));
      chk(word_sel == a[4:3], "R4 word_sel", 64'(word_sel), 64'(a[4:3]));
    end
    if (exp_hit && k == 2'd1)
      for (int b = 0; b < 8; b++)
        if (b >= int'(a[2:0]) && b < int'(a[2:0]) + (1 << sz))
          model[widx(a)][8*b +: 8] = d[8*b +: 8];
    @(negedge clk);
    acc_valid = 0;
    #1;
    if (exp_hit && k == 2'd0) begin
      chk(rd_valid == 1'b1, "R8 rd_valid", 64'(rd_valid), 64'd1);
      chk(rd_data == model[widx(a)], "R8/R9 rd_data", rd_data, model[widx(a)]);
    end else
      chk(rd_valid == 1'b0, "R8 rd_valid idle", 64'(rd_valid), 64'd0);
  endtask

  function automatic logic [31:0] waddr(input int w, input int mirror);
    return 32'h7C00_0000 | (32'(mirror) << 13) | (32'(w / 512) << 12) | (32'(w % 512) << 3);
  endfunction

  function automatic logic [63:0] pat(input int w);
    return {32'(w) * 32'h9E37_79B9, ~(32'(w) * 32'h85EB_CA6B)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid == 0 && rd_data == 0, "R8 reset state", rd_data, 64'd0);
    rst_n = 1;

    // R1: mode off
    chk(&alloc_mask, "R1 alloc all ones", 64'(alloc_mask[127:64]), {64{1'b1}});
    acc(32'h7C00_0000, 2'd3, 2'd1, 64'hFFFF, 0, 0);
    acc(32'h7C00_0020, 2'd2, 2'd2, 64'h0, 0, 0);

    // R10: index mode blocks RAM mode
    ram_en = 1; idx_mode = 1;
    @(negedge clk);
    chk(&alloc_mask, "R10 alloc all ones", 64'(alloc_mask[255:192]), {64{1'b1}});
    acc(32'h7C00_1000, 2'd0, 2'd0, 64'h0, 0, 0);
    idx_mode = 0;
    @(negedge clk);

    // R5: sweep allocation mask
    for (int i = 0; i < 512; i++)
      chk(alloc_mask[i] == !((i / 128) % 2 == 1), "R5 alloc_mask bit", 64'(alloc_mask[i]), 64'(i));

    // R2: window edges
    acc(32'h7BFF_FFF8, 2'd3, 2'd1, 64'h1, 0, 0);
    acc(32'h8000_0000, 2'd3, 2'd1, 64'h1, 0, 0);
    acc(32'h3C00_0000, 2'd3, 2'd0, 64'h0, 0, 0);

    // R8/R9: fill every word through mirror 5, read back through mirror 0x1A3
    for (int w = 0; w < 1024; w++) acc(waddr(w, 5), 2'd3, 2'd1, pat(w), 1, 0);
    for (int w = 0; w < 1024; w++) acc(waddr(w, 12'h1A3), 2'd3, 2'd0, 64'h0, 1, 0);

    // R8: narrow writes at every legal offset, varied mirrors
    for (int w = 0; w < 64; w++) begin
      for (int sz = 0; sz < 3; sz++)
        for (int o = 0; o < 8; o += (1 << sz))
          acc(waddr(w * 16 + 3, w + sz) | 32'(o), 2'(sz), 2'd1,
              ~pat(w + o + 16 * sz), 1, 0);
      acc(waddr(w * 16 + 3, 8191), 2'd3, 2'd0, 64'h0, 1, 0);
    end

    // R6: fetch and reserved kinds rejected, no write
    acc(waddr(7, 2), 2'd2, 2'd2, 64'h0, 0, 1);
    acc(waddr(7, 2), 2'd3, 2'd3, 64'hDEAD_BEEF_0000_0001, 0, 1);
    acc(waddr(7, 0), 2'd3, 2'd0, 64'h0, 1, 0);

    // R7: misaligned accesses for each size, no write
    for (int sz = 1; sz < 4; sz++)
      for (int o = 1; o < 8; o++)
        if ((o & ((1 << sz) - 1)) != 0) begin
          acc(waddr(600, 9) | 32'(o), 2'(sz), 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
          acc(waddr(600, 9) | 32'(o), 2'(sz), 2'd0, 64'h0, 0, 1);
        end
    acc(waddr(600, 3), 2'd3, 2'd0, 64'h0, 1, 0);

    // R1: turning mode off again hides the RAM
    ram_en = 0;
    acc(waddr(600, 3), 2'd3, 2'd0, 64'h0, 0, 0);
    @(negedge clk);
    chk(&alloc_mask, "R1 alloc restored", 64'(alloc_mask[511:448]), {64{1'b1}});
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule